// File: doc/BRIEF.md
# Prescaled 8-bit PWM Timer

An 8-bit timer/counter that generates one pulse-width-modulated waveform from a single compare channel. A free-running divider on the system clock produces single-cycle count enables at one of seven rates, or none. All logic runs in the one clock domain. The counter either wraps from 0xFF to 0x00 (fast PWM) or ramps from 0x00 up to 0xFF and back down (phase-correct PWM). A compare register, buffered and taken up at the top of each period, sets where the waveform changes level.

A host can stop the timer, write or read the counter, load a new compare value and pick the output polarity through a 2-bit output-mode field. Writing the counter masks the compare event on the next count step. This lets the host reposition the count without causing a spurious edge.

Top module: `pwm_timer8`

## Requirements
- R1: While reset is held and right after it, the count reads 0x00 and both `pwm_out` and `pwm_oe` are low.
- R2: A counter write (`cnt_we`) makes `cnt_q` show `cnt_wdata` from the next clock edge. A stopped counter keeps that value.
- R3: `clk_sel` sets the count step rate. 000 holds the count, 001 steps every clock, and 010, 011, 100, 101, 110 and 111 step once every 8, 32, 64, 128, 256 and 1024 clocks.
- R4: With `out_mode` 00 or 01, `pwm_oe` is low and `pwm_out` stays low. With `out_mode[1]` set, `pwm_oe` is high.
- R5: In fast PWM (`wave_pc`=0) with `out_mode` 10, `pwm_out` is high for compare+1 of every 256 steps.
- R6: In fast PWM with `out_mode` 11, `pwm_out` is high for 255-compare of every 256 steps.
- R7: In phase-correct PWM (`wave_pc`=1), each period is 510 steps. With `out_mode` 10 the output is high for 2·compare steps. With `out_mode` 11 it is high for 510-2·compare steps.
- R8: A compare value of 0xFF gives no compare event. Modes 10 then hold the output constantly high and modes 11 constantly low, in both waveform modes.
- R9: After a counter write, the next count step produces no compare event, even when the written value equals the compare value.
- R10: A value written through `cmp_we` takes effect only when the count steps away from 0xFF. The period in progress keeps the old threshold.
- R11: In fast PWM every step adds one modulo 256. In phase-correct PWM every step moves the count by exactly one, and the direction reverses at 0xFF and at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Step-rate select code |
| wave_pc | input | 1 | 0 = fast PWM, 1 = phase-correct PWM |
| out_mode | input | 2 | Output mode: 0x disconnected, 10 normal polarity, 11 inverted |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write value |
| cmp_we | input | 1 | Compare buffer write strobe |
| cmp_wdata | input | 8 | Compare buffer write value |
| cnt_q | output | 8 | Current count |
| pwm_out | output | 1 | Waveform output |
| pwm_oe | output | 1 | Output enable |

## Verification
A counter write shows on `cnt_q` one edge later. With `clk_sel`=001 each edge is a step, and `pwm_out` changes on the same edge as the step whose count matched. For that reason the bench drives and samples on falling edges. It either polls `cnt_q` for an exact count and checks the output on that same falling edge, or it counts high samples across a window of exactly one period. Duty windows open only after several full periods, so the buffered compare value has been taken up. Rate checks use windows of eight divider periods, so every tap must give exactly eight steps whatever the divider phase.

// File: rtl/pwm_timer8.sv
module pwm_timer8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       wave_pc,
  input  logic [1:0] out_mode,
  input  logic       cnt_we,
  input  logic [7:0] cnt_wdata,
  input  logic       cmp_we,
  input  logic [7:0] cmp_wdata,
  output logic [7:0] cnt_q,
  output logic       pwm_out,
  output logic       pwm_oe
);
  localparam logic [7:0] TOP = 8'hFF;
  localparam logic [7:0] BOT = 8'h00;

  logic [9:0] pre_q;
  logic       tick;
  logic [7:0] cnt_r, cmp_buf, cmp_act;
  logic       dir_up, blk, wave_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 10'd1;

  always_comb
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[4:0];
      3'd4:    tick = &pre_q[5:0];
      3'd5:    tick = &pre_q[6:0];
      3'd6:    tick = &pre_q[7:0];
      3'd7:    tick = &pre_q[9:0];
      default: tick = 1'b0;
    endcase

  wire at_top  = cnt_r == TOP;
  wire at_bot  = cnt_r == BOT;
  wire step_up = !wave_pc || (dir_up ? !at_top : at_bot);
  wire cmp_top = cmp_act == TOP;
  wire hit     = tick && !blk && cnt_r == cmp_act && !(cmp_top && out_mode[1]);
  wire inv     = out_mode[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_r  <= BOT;
      dir_up <= 1'b1;
      blk    <= 1'b0;
    end else if (cnt_we) begin
      cnt_r <= cnt_wdata;
      blk   <= 1'b1;
    end else if (tick) begin
      cnt_r  <= step_up ? cnt_r + 8'd1 : cnt_r - 8'd1;
      dir_up <= step_up;
      blk    <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_buf <= BOT;
      cmp_act <= BOT;
    end else begin
      if (cmp_we) cmp_buf <= cmp_wdata;
      if (tick && at_top) cmp_act <= cmp_buf;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wave_q <= 1'b0;
    else if (tick) begin
      if (!wave_pc) begin
        if (at_top)   wave_q <= !inv;
        else if (hit) wave_q <= inv;
      end else begin
        if (hit)                  wave_q <= step_up ? inv : !inv;
        else if (at_top && cmp_top) wave_q <= !inv;
      end
    end

  assign cnt_q   = cnt_r;
  assign pwm_oe  = out_mode[1];
  assign pwm_out = out_mode[1] & wave_q;
endmodule

module pwm_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] clk_sel,
  input logic       wave_pc,
  input logic       cnt_we,
  input logic [7:0] cnt_wdata,
  input logic [7:0] cnt_q,
  input logic       pwm_out,
  input logic       pwm_oe
);
  // R2
  cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_we) |=> cnt_q == $past(cnt_q));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_oe |-> !pwm_out);

  // R11
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wave_pc && clk_sel == 3'd1 && !cnt_we) |=> cnt_q == 8'($past(cnt_q) + 8'd1));

  // R11
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_pc && clk_sel == 3'd1 && !cnt_we) |=>
      (cnt_q == 8'($past(cnt_q) + 8'd1) || cnt_q == 8'($past(cnt_q) - 8'd1)));
endmodule

bind pwm_timer8 pwm_timer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_pc(wave_pc),
  .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm_timer8_bench.sv
`timescale 1ns/1ps
module pwm_timer8_bench;
  logic       clk = 0, rst_n = 0;
  logic [2:0] clk_sel = 0;
  logic       wave_pc = 0;
  logic [1:0] out_mode = 0;
  logic       cnt_we = 0, cmp_we = 0;
  logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [7:0] cnt_q;
  logic       pwm_out, pwm_oe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_timer8 u_pwm_timer8 (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .wave_pc(wave_pc),
    .out_mode(out_mode), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cnt_q(cnt_q),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cnt(input logic [7:0] v);
    @(negedge clk);
    while (cnt_q != v) @(negedge clk);
  endtask

  task automatic write_cnt(input logic [7:0] v);
    cnt_we = 1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 0;
  endtask

  task automatic t_reset;
    check(cnt_q == 0, "R1 count", cnt_q, 0);
    check(!pwm_out && !pwm_oe, "R1 out/oe", {pwm_out, pwm_oe}, 0);
  endtask

  task automatic t_rw;
    clk_sel = 0;
    @(negedge clk);
    write_cnt(8'hA5);
    check(cnt_q == 8'hA5, "R2 readback", cnt_q, 8'hA5);
    repeat (10) @(negedge clk);
    check(cnt_q == 8'hA5, "R2 hold stopped", cnt_q, 8'hA5);
  endtask

  task automatic t_rates;
    int div [8] = '{0, 1, 8, 32, 64, 128, 256, 1024};
    wave_pc = 0;
    for (int s = 0; s < 8; s++) begin
      logic [7:0] c0, d;
      int w, exp;
      clk_sel = 3'(s);
      w   = (s == 0) ? 100 : 8 * div[s];
      exp = (s == 0) ? 0 : 8;
      @(negedge clk);
      c0 = cnt_q;
      repeat (w) @(negedge clk);
      d = cnt_q - c0;
      check(d == 8'(exp), $sformatf("R3 sel=%0d", s), d, exp);
    end
  endtask

  task automatic t_disc;
    int hi;
    clk_sel = 1; wave_pc = 0;
    cmp_we = 1; cmp_wdata = 8'h80;
    @(negedge clk); cmp_we = 0;
    for (int m = 0; m < 2; m++) begin
      out_mode = 2'(m); hi = 0;
      repeat (600) begin @(negedge clk); if (pwm_out || pwm_oe) hi++; end
      check(hi == 0, $sformatf("R4 mode %0d disconnected", m), hi, 0);
    end
    out_mode = 2'b10;
    @(negedge clk);
    check(pwm_oe, "R4 oe driven", pwm_oe, 1);
  endtask

  task automatic t_duty(input bit pc, input bit inv, input logic [7:0] cmp,
                        input int exp, input string tag);
    int hi, per;
    per = pc ? 510 : 256;
    clk_sel = 1; wave_pc = pc; out_mode = {1'b1, inv};
    cmp_we = 1; cmp_wdata = cmp;
    @(negedge clk); cmp_we = 0;
    repeat (1600) @(negedge clk);
    hi = 0;
    repeat (per) begin if (pwm_out) hi++; @(negedge clk); end
    check(hi == exp, $sformatf("%s cmp=%0d", tag, cmp), hi, exp);
  endtask

  task automatic t_suppress;
    clk_sel = 1; wave_pc = 0; out_mode = 2'b10;
    cmp_we = 1; cmp_wdata = 8'h80;
    @(negedge clk); cmp_we = 0;
    repeat (600) @(negedge clk);
    wait_cnt(8'h10);
    write_cnt(8'h80);
    check(cnt_q == 8'h80, "R9 write landed", cnt_q, 8'h80);
    @(negedge clk);
    check(cnt_q == 8'h81, "R9 stepped", cnt_q, 8'h81);
    check(pwm_out == 1, "R9 match masked", pwm_out, 1);
    wait_cnt(8'h81);
    check(pwm_out == 0, "R9 next period matches", pwm_out, 0);
  endtask

  task automatic t_buffer;
    clk_sel = 1; wave_pc = 0; out_mode = 2'b10;
    cmp_we = 1; cmp_wdata = 8'h80;
    @(negedge clk); cmp_we = 0;
    repeat (600) @(negedge clk);
    wait_cnt(8'h05);
    cmp_we = 1; cmp_wdata = 8'h20;
    @(negedge clk); cmp_we = 0;
    wait_cnt(8'h30);
    check(pwm_out == 1, "R10 old threshold kept", pwm_out, 1);
    wait_cnt(8'h90);
    check(pwm_out == 0, "R10 old threshold cleared", pwm_out, 0);
    wait_cnt(8'h05);
    check(pwm_out == 1, "R10 set at bottom", pwm_out, 1);
    wait_cnt(8'h30);
    check(pwm_out == 0, "R10 new threshold", pwm_out, 0);
  endtask

  task automatic t_pc_turn;
    logic [7:0] a, b;
    clk_sel = 1; wave_pc = 1;
    wait_cnt(8'hFF);
    @(negedge clk); a = cnt_q;
    check(a == 8'hFE, "R11 reverse at top", a, 8'hFE);
    wait_cnt(8'h00);
    @(negedge clk); b = cnt_q;
    check(b == 8'h01, "R11 reverse at bottom", b, 8'h01);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_rates();
    t_disc();
    t_duty(0, 0, 8'h00, 1,   "R5");
    t_duty(0, 0, 8'h80, 129, "R5");
    t_duty(0, 0, 8'hFF, 256, "R8 fast noninv");
    t_duty(0, 1, 8'h00, 255, "R6");
    t_duty(0, 1, 8'h40, 191, "R6");
    t_duty(0, 1, 8'hFF, 0,   "R8 fast inv");
    t_duty(1, 0, 8'h00, 0,   "R7 pc");
    t_duty(1, 0, 8'h40, 128, "R7 pc");
    t_duty(1, 0, 8'hFF, 510, "R8 pc noninv");
    t_duty(1, 1, 8'h00, 510, "R7 pc inv");
    t_duty(1, 1, 8'h80, 254, "R7 pc inv");
    t_duty(1, 1, 8'hFF, 0,   "R8 pc inv");
    t_suppress();
    t_buffer();
    t_pc_turn();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule